// File: doc/BRIEF.md
# Four-phase handshake clock-domain word transfer

This block carries one multi-bit word at a time from a source clock domain into an unrelated destination clock domain. The source accepts a word with a valid/ready exchange and places it in a register that drives the crossing bus. It holds that register steady for a set number of source cycles and only then raises a request. The request reaches the destination through a chain of synchronizer flops. The destination samples the bus when the synchronized request goes high, because the bus has not changed since before the request rose. It then reports the word with a single-cycle strobe and raises an acknowledge.

The acknowledge returns through its own synchronizer chain. When the source sees it high, it drops the request. The destination then drops the acknowledge after the synchronized request reads low. The source counts as idle again only when the returned acknowledge reads low. At that point all four phases are complete and the next word may be taken. Each domain has its own clock and its own synchronous active-low reset. The synchronizer chains make metastable values less likely; they do not rule them out.

Top module: `hs_cdc_xfer`

## Requirements
- R1: After reset, `src_busy` is 0, `src_ready` is 1, `dst_strobe` is 0 and `dst_data` is all zeros.
- R2: A word on `src_data` is accepted at a source clock edge where `src_valid` and `src_ready` are both 1, and `src_busy` reads 1 from the next source cycle on.
- R3: From acceptance until `src_busy` falls, the crossing bus holds the accepted word, and `src_valid`/`src_data` are ignored: a word offered while busy is never delivered.
- R4: The request rises only after the bus has held the word for at least `SETUP_CYC` (minimum 1) source cycles, so `dst_strobe` for a word comes no earlier than `SETUP_CYC` source periods plus `SYNC_DEPTH` destination periods after its acceptance.
- R5: Each accepted word produces exactly one `dst_strobe` pulse, one destination cycle wide, with `dst_data` equal to that word; words arrive in acceptance order, with none lost and none duplicated.
- R6: `src_ready` equals the inverse of `src_busy` at all times.
- R7: `src_busy` falls only after the whole handshake has returned to zero, which means after the word has been delivered at the destination; the request falls only while the synchronized acknowledge is high.
- R8: Between strobes, `dst_data` keeps the last delivered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain synchronous reset, active low |
| src_valid | input | 1 | Source offers a word |
| src_data | input | DATA_W | Word offered by the source |
| src_ready | output | 1 | Source side can accept a word this cycle |
| src_busy | output | 1 | A transfer is in progress |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain synchronous reset, active low |
| dst_strobe | output | 1 | One-cycle pulse when a word arrives |
| dst_data | output | DATA_W | Last delivered word |

## Verification
The two clocks run at 10 ns and 17 ns, so the handshake edges fall at drifting phase offsets between the domains. Words are sent with varying idle gaps and also back to back. Back-to-back sending shows whether a new word can slip in before the return-to-zero is finished. Some transfers have a conflicting word held on the input for the whole busy period. Any delivery of that word reveals a source that does not ignore input while busy. The all-zeros and all-ones words, together with an order-checked queue and a lower bound on latency, separate lost, duplicated, reordered or early captures.

// File: rtl/hs_cdc_pkg.sv
package hs_cdc_pkg;
    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_SETUP = 2'd1,
        SRC_REQ   = 2'd2,
        SRC_DRAIN = 2'd3
    } src_state_e;
endpackage

// File: rtl/hs_sync_chain.sv
module hs_sync_chain #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [DEPTH-1:0] stage_d, stage_q;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign stage_d[g] = async_in;
            end else begin : g_next
                assign stage_d[g] = stage_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_out = stage_q[DEPTH-1];
endmodule

// File: rtl/hs_src_side.sv
module hs_src_side
    import hs_cdc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SETUP_CYC  = 1,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              busy,
    output logic              req,
    output logic [DATA_W-1:0] bus_data,
    input  logic              ack_async
);
    localparam int CNT_W = $clog2(SETUP_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETUP_CYC - 1);

    typedef struct packed {
        src_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              req;
        logic [DATA_W-1:0] data;
    } src_regs_t;

    src_regs_t r_d, r_q;
    logic      ack_s;

    hs_sync_chain #(.DEPTH(SYNC_DEPTH)) u_ack_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ack_async),
        .sync_out (ack_s)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            SRC_IDLE: begin
                if (in_valid && !ack_s) begin
                    r_d.data  = in_data;
                    r_d.cnt   = '0;
                    r_d.state = SRC_SETUP;
                end
            end
            SRC_SETUP: begin
                if (r_q.cnt == CNT_LAST) begin
                    r_d.req   = 1'b1;
                    r_d.state = SRC_REQ;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            SRC_REQ: begin
                if (ack_s) begin
                    r_d.req   = 1'b0;
                    r_d.state = SRC_DRAIN;
                end
            end
            SRC_DRAIN: begin
                if (!ack_s) r_d.state = SRC_IDLE;
            end
            default: r_d.state = SRC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= SRC_IDLE;
            r_q.cnt   <= '0;
            r_q.req   <= 1'b0;
            r_q.data  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready = (r_q.state == SRC_IDLE) && !ack_s;
    assign busy     = (r_q.state != SRC_IDLE);
    assign req      = r_q.req;
    assign bus_data = r_q.data;

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);
    p_bus_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bus_data));
    p_setup_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> ($stable(bus_data) && $past(busy)));
    p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(ack_s));
    p_ready_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);
endmodule

// File: rtl/hs_dst_side.sv
module hs_dst_side #(
    parameter int DATA_W     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_async,
    input  logic [DATA_W-1:0] bus_data,
    output logic              ack,
    output logic              strobe,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic              req_prev;
        logic              ack;
        logic              strobe;
        logic [DATA_W-1:0] data;
    } dst_regs_t;

    dst_regs_t r_d, r_q;
    logic      req_s;

    hs_sync_chain #(.DEPTH(SYNC_DEPTH)) u_req_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (req_async),
        .sync_out (req_s)
    );

    always_comb begin
        r_d          = r_q;
        r_d.req_prev = req_s;
        r_d.strobe   = req_s && !r_q.req_prev;
        r_d.ack      = req_s;
        if (req_s && !r_q.req_prev) r_d.data = bus_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.req_prev <= 1'b0;
            r_q.ack      <= 1'b0;
            r_q.strobe   <= 1'b0;
            r_q.data     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack      = r_q.ack;
    assign strobe   = r_q.strobe;
    assign out_data = r_q.data;

    p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> $stable(out_data));
    p_ack_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> strobe);
endmodule

// File: rtl/hs_cdc_xfer.sv
module hs_cdc_xfer #(
    parameter int DATA_W     = 8,
    parameter int SETUP_CYC  = 1,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    output logic              src_busy,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    output logic              dst_strobe,
    output logic [DATA_W-1:0] dst_data
);
    logic              req_x;
    logic              ack_x;
    logic [DATA_W-1:0] bus_x;

    initial begin
        if (SETUP_CYC < 1)  $error("SETUP_CYC must be at least 1");
        if (SYNC_DEPTH < 2) $error("SYNC_DEPTH must be at least 2");
    end

    hs_src_side #(
        .DATA_W     (DATA_W),
        .SETUP_CYC  (SETUP_CYC),
        .SYNC_DEPTH (SYNC_DEPTH)
    ) u_src (
        .clk       (src_clk),
        .rst_n     (src_rst_n),
        .in_valid  (src_valid),
        .in_data   (src_data),
        .in_ready  (src_ready),
        .busy      (src_busy),
        .req       (req_x),
        .bus_data  (bus_x),
        .ack_async (ack_x)
    );

    hs_dst_side #(
        .DATA_W     (DATA_W),
        .SYNC_DEPTH (SYNC_DEPTH)
    ) u_dst (
        .clk       (dst_clk),
        .rst_n     (dst_rst_n),
        .req_async (req_x),
        .bus_data  (bus_x),
        .ack       (ack_x),
        .strobe    (dst_strobe),
        .out_data  (dst_data)
    );
endmodule

// File: tb/hs_cdc_xfer_tb.sv
`timescale 1ns/100ps
module hs_cdc_xfer_tb;
    localparam real SRC_T  = 10.0;
    localparam real DST_T  = 17.0;
    localparam int  W      = 16;
    localparam int  SETUP  = 2;
    localparam int  SYNC   = 3;
    localparam int  NWORDS = 24;

    logic src_clk = 0, dst_clk = 0;
    logic src_rst_n = 0, dst_rst_n = 0;
    logic src_valid = 0;
    logic [W-1:0] src_data = '0;
    logic src_ready, src_busy, dst_strobe;
    logic [W-1:0] dst_data;

    int checks = 0, errors = 0;
    int accepted = 0, delivered = 0;
    bit running = 0, done = 0;
    logic [W-1:0] exp_q[$];
    real          t_q[$];

    always #(SRC_T/2) src_clk = ~src_clk;
    always #(DST_T/2) dst_clk = ~dst_clk;

    hs_cdc_xfer #(.DATA_W(W), .SETUP_CYC(SETUP), .SYNC_DEPTH(SYNC)) u_dut (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
        .src_data(src_data), .src_ready(src_ready), .src_busy(src_busy),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_strobe(dst_strobe),
        .dst_data(dst_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] word_of(input int i);
        if (i == 0) return '0;
        if (i == 1) return '1;
        return W'(i * 16'h3B7) ^ 16'hA5C3;
    endfunction

    // Source-side per-cycle model comparison
    logic prev_busy = 0;
    always @(negedge src_clk) if (running) begin
        check(src_ready == !src_busy, "R6 ready/busy", src_ready, !src_busy);
        if (prev_busy && !src_busy)
            check(delivered == accepted, "R7 busy fell before delivery", delivered, accepted);
        prev_busy = src_busy;
    end

    // Destination-side per-cycle model comparison
    logic         prev_strobe = 0;
    logic [W-1:0] last_data = '0;
    always @(negedge dst_clk) if (running) begin
        if (dst_strobe) begin
            check(!prev_strobe, "R5 strobe width", 1, 0);
            if (exp_q.size() == 0) begin
                check(0, "R5 unexpected word", dst_data, 0);
            end else begin
                logic [W-1:0] e;
                real          ta, lat;
                e  = exp_q.pop_front();
                ta = t_q.pop_front();
                check(dst_data == e, "R5 word value/order", dst_data, e);
                lat = ($realtime - DST_T/2) - ta;
                check(lat >= SETUP*SRC_T + SYNC*DST_T - 0.05, "R4 latency",
                      longint'(lat), longint'(SETUP*SRC_T + SYNC*DST_T));
            end
            delivered++;
            last_data = dst_data;
        end else begin
            check(dst_data == last_data, "R8 data hold", dst_data, last_data);
        end
        prev_strobe = dst_strobe;
    end

    task automatic send(input logic [W-1:0] w, input bit junk);
        @(negedge src_clk);
        src_valid = 1; src_data = w;
        #1;
        while (!src_ready) begin
            @(negedge src_clk); #1;
        end
        exp_q.push_back(w);
        t_q.push_back($realtime - 1 + SRC_T/2);
        accepted++;
        @(negedge src_clk);
        check(src_busy == 1, "R2 busy after accept", src_busy, 1);
        if (junk) begin
            src_data = ~w ^ 16'h0101;
            while (src_busy) @(negedge src_clk);
            src_valid = 0;
        end else begin
            src_valid = 0;
            while (src_busy) @(negedge src_clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge src_clk);
        @(negedge dst_clk);
        src_rst_n = 1; dst_rst_n = 1;
        @(negedge dst_clk);
        @(negedge src_clk);
        check(src_busy == 0, "R1 busy reset", src_busy, 0);
        check(src_ready == 1, "R1 ready reset", src_ready, 1);
        check(dst_strobe == 0, "R1 strobe reset", dst_strobe, 0);
        check(dst_data == '0, "R1 data reset", dst_data, 0);
        running = 1;
        for (int i = 0; i < NWORDS; i++) begin
            send(word_of(i), (i % 3) == 1);   // R3: conflicting input while busy
            repeat (i % 4) @(negedge src_clk);
        end
        for (int k = 0; k < 200 && delivered < accepted; k++) @(negedge dst_clk);
        repeat (10) @(negedge dst_clk);
        check(delivered == NWORDS, "R5 delivered count", delivered, NWORDS);
        check(exp_q.size() == 0, "R3 leftover expected words", exp_q.size(), 0);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge src_clk);
        if (!done) check(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule